// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a parameterised number of asynchronous input lines (up to 64, 40 by default), brings each one into the clock domain and looks for rising and falling transitions. A transition that software has selected for a line latches a pending flag. A per-line interrupt enable gates that latch. The enable also gates the flag's path to a small set of shared interrupt request outputs. A separate per-line event output gives a one-clock pulse on every selected edge of a line whose event enable is set. The pending state plays no part in that pulse.

Software reaches the block through a plain word-addressed register port. The port has an address, a write strobe, write data and combinational read data, with no handshake, because each access completes in one cycle. Each group of 32 lines owns a bank of six registers. Lines 32 and up sit in a second bank placed right after the first. Pending flags are cleared by writing ones. A software trigger register lets firmware raise a pending flag without any edge on the input. A build parameter picks one of two ways of folding lines onto request outputs.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and all request and event outputs are low.
- R2: Register word address 6*b+k selects bank b (lines 32*b to 32*b+31, bit index = line - 32*b). The register k is: 0 interrupt enable, 1 event enable, 2 rising select, 3 falling select, 4 software trigger, 5 pending. The first four read back what was written.
- R3: Bits for lines at or above NUM_LINES read zero and ignore writes. So do word addresses beyond the last implemented bank.
- R4: An input change is synchronised by two flops. A selected rising or falling edge of a line with its interrupt enable set shows in the pending register on the third rising clock edge after the input changes. Rising and falling selects are independent, and a line with both set latches on either edge.
- R5: A selected edge on a line whose interrupt enable is 0 leaves its pending bit unchanged.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R7: When a pending bit is set and cleared in the same cycle, the set takes effect.
- R8: Writing 1 to a software trigger bit of an enabled line sets its pending bit on that clock edge. The trigger bit then reads 1 until the pending bit is cleared. On a line that is not enabled, the write has no effect.
- R9: A selected edge on a line whose event enable is 1 gives exactly one one-clock pulse on that line's event output, whatever its interrupt enable and pending state.
- R10: A request output is high exactly when some line in its group is both pending and enabled, so clearing an enable bit drops that line's contribution at once.
- R11: With COMPACT_MAP = 0 there are seven request outputs. Outputs 0 to 4 follow lines 0 to 4 one to one, output 5 covers lines 5 to 9 and output 6 covers lines 10 to 15.
- R12: With COMPACT_MAP = 1 there are three request outputs, covering lines 0-1, 2-3 and 4-15. In both maps, lines above 15 latch pending but drive no request output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_i | input | NUM_LINES | Asynchronous external lines |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register, combinational |
| irq_o | output | NUM_IRQ | Grouped interrupt requests (7 or 3) |
| evt_o | output | NUM_LINES | Per-line event pulses |

## Verification
The bench builds two copies side by side on shared stimulus. One has NUM_LINES = 40 with the one-to-one map. This exercises the second bank, a partly filled upper bank, and lines 32 to 39 that latch without any request output. The other has NUM_LINES = 19 with the compact map. This exercises unimplemented bits inside the first bank and a missing second bank that must read zero, and checks that lines 16 to 18 latch but stay silent on the request outputs. Both are compared against one behavioural model of the register state.

// File: rtl/eic_pkg.sv
package eic_pkg;

  localparam int REGS_PER_BANK = 6;
  localparam int BANK_W        = 32;

  typedef enum logic [2:0] {
    RG_IMASK  = 3'd0,
    RG_EMASK  = 3'd1,
    RG_RISE   = 3'd2,
    RG_FALL   = 3'd3,
    RG_SWTRIG = 3'd4,
    RG_PEND   = 3'd5
  } reg_sel_e;

  // request output count for a grouping choice
  function automatic int irq_count(bit compact);
    return compact ? 3 : 7;
  endfunction

  // request output index for a line, -1 when the line drives none
  function automatic int group_of(int line, bit compact);
    if (line > 15) return -1;
    if (compact) begin
      if (line < 2) return 0;
      if (line < 4) return 1;
      return 2;
    end
    if (line < 5)  return line;
    if (line < 10) return 5;
    return 6;
  endfunction

endpackage

// File: rtl/eic_sync_edge.sv
module eic_sync_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;

endmodule

// File: rtl/eic_bank.sv
module eic_bank
  import eic_pkg::*;
#(
  parameter int BL = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  reg_sel_e      sel_i,
  input  logic [BL-1:0] wdata_i,
  input  logic [BL-1:0] rise_i,
  input  logic [BL-1:0] fall_i,
  output logic [31:0]   rdata_o,
  output logic [BL-1:0] pend_o,
  output logic [BL-1:0] imask_o,
  output logic [BL-1:0] emask_o,
  output logic [BL-1:0] trig_o,
  output logic [BL-1:0] evt_o
);

  logic [BL-1:0] imask_q, emask_q, rsel_q, fsel_q, sw_q, pend_q;
  logic [BL-1:0] trig, sw_set, pend_clr, pend_set;

  assign trig     = (rise_i & rsel_q) | (fall_i & fsel_q);
  assign sw_set   = (we_i && sel_i == RG_SWTRIG) ? (wdata_i & imask_q) : '0;
  assign pend_clr = (we_i && sel_i == RG_PEND) ? wdata_i : '0;
  assign pend_set = (trig & imask_q) | sw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= '0;
      emask_q <= '0;
      rsel_q  <= '0;
      fsel_q  <= '0;
      sw_q    <= '0;
      pend_q  <= '0;
    end else begin
      if (we_i) begin
        case (sel_i)
          RG_IMASK: imask_q <= wdata_i;
          RG_EMASK: emask_q <= wdata_i;
          RG_RISE:  rsel_q  <= wdata_i;
          RG_FALL:  fsel_q  <= wdata_i;
          default:  ;
        endcase
      end
      // a set in the same cycle as a clear wins
      pend_q <= pend_set | (pend_q & ~pend_clr);
      sw_q   <= sw_set | (sw_q & ~pend_clr);
    end
  end

  always_comb begin
    case (sel_i)
      RG_IMASK:  rdata_o = 32'(imask_q);
      RG_EMASK:  rdata_o = 32'(emask_q);
      RG_RISE:   rdata_o = 32'(rsel_q);
      RG_FALL:   rdata_o = 32'(fsel_q);
      RG_SWTRIG: rdata_o = 32'(sw_q);
      RG_PEND:   rdata_o = 32'(pend_q);
      default:   rdata_o = '0;
    endcase
  end

  assign pend_o  = pend_q;
  assign imask_o = imask_q;
  assign emask_o = emask_q;
  assign trig_o  = trig;
  assign evt_o   = trig & emask_q;

endmodule

// File: rtl/eic_irq_map.sv
module eic_irq_map
  import eic_pkg::*;
#(
  parameter int NL      = 40,
  parameter bit COMPACT = 1'b0,
  parameter int NIRQ    = 7
) (
  input  logic [NL-1:0]   act_i,
  output logic [NIRQ-1:0] irq_o
);

  for (genvar g = 0; g < NIRQ; g++) begin : g_irq
    logic [NL-1:0] member;
    for (genvar l = 0; l < NL; l++) begin : g_ln
      assign member[l] = (group_of(l, COMPACT) == g);
    end
    assign irq_o[g] = |(act_i & member);
  end

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter  int NUM_LINES   = 40,
  parameter  bit COMPACT_MAP = 1'b0,
  parameter  int ADDR_W      = 4,
  localparam int NUM_IRQ     = irq_count(COMPACT_MAP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_we,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_IRQ-1:0]   irq_o,
  output logic [NUM_LINES-1:0] evt_o
);

  localparam int NUM_BANKS = (NUM_LINES + BANK_W - 1) / BANK_W;
  localparam int LW        = NUM_BANKS * BANK_W;
  localparam int NUM_WORDS = NUM_BANKS * REGS_PER_BANK;

  logic [NUM_LINES-1:0] rise, fall, act_l, emask_l;
  logic [LW-1:0]        pend_w, imask_w, trig_w;
  logic [31:0]          rd_part [NUM_BANKS];
  int unsigned          bank_idx;
  logic [2:0]           sel;
  logic                 addr_ok;

  eic_sync_edge #(.W(NUM_LINES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (lines_i),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  always_comb begin
    bank_idx = 32'(reg_addr) / REGS_PER_BANK;
    sel      = 3'(32'(reg_addr) % REGS_PER_BANK);
    addr_ok  = 32'(reg_addr) < NUM_WORDS;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BL = (NUM_LINES - BANK_W * b > BANK_W) ? BANK_W : NUM_LINES - BANK_W * b;
    logic          we_b;
    logic [31:0]   rd_b;
    logic [BL-1:0] pend_b, imask_b, emask_b, trig_b, evt_b;

    assign we_b = reg_we && addr_ok && (bank_idx == b);

    eic_bank #(.BL(BL)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we_b),
      .sel_i   (reg_sel_e'(sel)),
      .wdata_i (reg_wdata[BL-1:0]),
      .rise_i  (rise[BANK_W*b +: BL]),
      .fall_i  (fall[BANK_W*b +: BL]),
      .rdata_o (rd_b),
      .pend_o  (pend_b),
      .imask_o (imask_b),
      .emask_o (emask_b),
      .trig_o  (trig_b),
      .evt_o   (evt_b)
    );

    assign rd_part[b]                 = (addr_ok && bank_idx == b) ? rd_b : '0;
    assign evt_o[BANK_W*b +: BL]      = evt_b;
    assign act_l[BANK_W*b +: BL]      = pend_b & imask_b;
    assign emask_l[BANK_W*b +: BL]    = emask_b;
    assign pend_w[BANK_W*b +: BANK_W]  = 32'(pend_b);
    assign imask_w[BANK_W*b +: BANK_W] = 32'(imask_b);
    assign trig_w[BANK_W*b +: BANK_W]  = 32'(trig_b);
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) reg_rdata = reg_rdata | rd_part[b];
  end

  eic_irq_map #(.NL(NUM_LINES), .COMPACT(COMPACT_MAP), .NIRQ(NUM_IRQ)) u_map (
    .act_i (act_l),
    .irq_o (irq_o)
  );

endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int NL = 40,
  parameter int NI = 7,
  parameter int LW = 64,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [NI-1:0] irq_o,
  input logic [NL-1:0] evt_o,
  input logic [NL-1:0] emask_l,
  input logic [LW-1:0] pend_w,
  input logic [LW-1:0] imask_w,
  input logic [LW-1:0] trig_w
);

  // R1
  irq_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (irq_o == '0));

  // R10
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> (|(pend_w & imask_w)));

  // R9
  evt_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o & ~emask_l) == '0);

  // R8
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_w & ~$past(pend_w) & ~$past(trig_w)) != '0)
      |-> $past(reg_we && (reg_addr == AW'(4) || reg_addr == AW'(10))));

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == AW'(5))
      |-> ((pend_w[31:0] & $past(reg_wdata) & ~$past(trig_w[31:0])) == '0));

endmodule

bind edge_irq_ctrl eic_checker #(.NL(NUM_LINES), .NI(NUM_IRQ), .LW(LW), .AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_o     (irq_o),
  .evt_o     (evt_o),
  .emask_l   (emask_l),
  .pend_w    (pend_w),
  .imask_w   (imask_w),
  .trig_w    (trig_w)
);

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NA = 40;
  localparam int NC = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NA-1:0] lines = '0;
  logic [3:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rd_a, rd_c;
  logic [6:0]    irq_a;
  logic [2:0]    irq_c;
  logic [NA-1:0] evt_a;
  logic [NC-1:0] evt_c;
  logic [NA-1:0] evt_cw;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [63:0] m [0:1][0:5];
  logic [63:0] impl [0:1];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign evt_cw = NA'(evt_c);

  edge_irq_ctrl #(.NUM_LINES(NA), .COMPACT_MAP(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rd_a), .irq_o(irq_a), .evt_o(evt_a));

  edge_irq_ctrl #(.NUM_LINES(NC), .COMPACT_MAP(1'b1)) u_dut_c (
    .clk(clk), .rst_n(rst_n), .lines_i(lines[NC-1:0]), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rd_c), .irq_o(irq_c), .evt_o(evt_c));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(int i, int a);
    if (a >= 12) return 32'h0;
    return 32'(m[i][a % 6] >> (32 * (a / 6)));
  endfunction

  function automatic logic [6:0] exp_irq(int i);
    logic [63:0] act;
    logic [6:0]  r;
    act = m[i][5] & m[i][0];
    r = '0;
    if (i == 0) begin
      r[4:0] = act[4:0];
      r[5]   = |act[9:5];
      r[6]   = |act[15:10];
    end else begin
      r[0] = |act[1:0];
      r[1] = |act[3:2];
      r[2] = |act[15:4];
    end
    return r;
  endfunction

  task automatic model_wr(int a, logic [31:0] d);
    for (int i = 0; i < 2; i++) begin
      int k;
      int sh;
      logic [63:0] d64, fm, s;
      if (a < 12) begin
        k   = a % 6;
        sh  = 32 * (a / 6);
        d64 = (64'(d) << sh) & impl[i];
        fm  = 64'hFFFF_FFFF << sh;
        case (k)
          4: begin
            s = d64 & m[i][0];
            m[i][4] = m[i][4] | s;
            m[i][5] = m[i][5] | s;
          end
          5: begin
            m[i][5] = m[i][5] & ~d64;
            m[i][4] = m[i][4] & ~d64;
          end
          default: m[i][k] = (m[i][k] & ~fm) | d64;
        endcase
      end
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    addr = 4'(a);
    wdata = d;
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(int a, string tag);
    @(negedge clk);
    addr = 4'(a);
    #1;
    check({tag, " wide"}, rd_a, exp_rd(0, a));
    check({tag, " compact"}, rd_c, exp_rd(1, a));
  endtask

  task automatic irq_chk(string tag);
    logic [6:0] ea, ec;
    ea = exp_irq(0);
    ec = exp_irq(1);
    check({tag, " irq wide"}, 32'(irq_a), 32'(ea));
    check({tag, " irq compact"}, 32'(irq_c), 32'(ec[2:0]));
  endtask

  // flips one line, checks pending timing (R4) and event pulse count (R9)
  task automatic toggle(int line);
    logic rising;
    logic [31:0] old_a, old_c;
    int ca, cc, pa, ea, ec;
    int e_exp [0:1];
    ca = 0;
    cc = 0;
    pa = 5 + 6 * (line / 32);
    @(negedge clk);
    lines[line] = ~lines[line];
    rising = lines[line];
    addr = 4'(pa);
    old_a = exp_rd(0, pa);
    old_c = exp_rd(1, pa);
    for (int i = 0; i < 2; i++) begin
      logic t;
      t = impl[i][line] && (rising ? m[i][2][line] : m[i][3][line]);
      e_exp[i] = (t && m[i][1][line]) ? 1 : 0;
      if (t && m[i][0][line]) m[i][5][line] = 1'b1;
    end
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      #1;
      ca += int'(evt_a[line]);
      cc += int'(evt_cw[line]);
      if (n == 2) begin
        check("R4 pending before third edge wide", rd_a, old_a);
        check("R4 pending before third edge compact", rd_c, old_c);
      end
      if (n == 3) begin
        check("R4 pending at third edge wide", rd_a, exp_rd(0, pa));
        check("R4 pending at third edge compact", rd_c, exp_rd(1, pa));
      end
    end
    ea = e_exp[0];
    ec = e_exp[1];
    check("R9 event pulses wide", 32'(ca), 32'(ea));
    check("R9 event pulses compact", 32'(cc), 32'(ec));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < 6; k++) m[i][k] = '0;
    impl[0] = 64'h0000_00FF_FFFF_FFFF;
    impl[1] = 64'h0000_0000_0007_FFFF;
    void'($urandom(32'd20240611));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 12; a++) rd_chk(a, "R1 reset read");
    irq_chk("R1");
    check("R1 events low wide", 32'(evt_a != '0), 32'h0);
    check("R1 events low compact", 32'(evt_c != '0), 32'h0);

    // R2 / R3 map and unimplemented bits
    wr(0, 32'hFFFF_FFFF);
    rd_chk(0, "R2 enable readback");
    check("R3 compact bank0 upper bits", rd_c, 32'h0007_FFFF);
    wr(6, 32'hFFFF_FFFF);
    rd_chk(6, "R2 bank1 enable");
    check("R3 wide bank1 upper bits", rd_a, 32'h0000_00FF);
    check("R3 compact bank1 absent", rd_c, 32'h0);
    rd_chk(12, "R3 address past banks");
    wr(1, 32'hA5A5_0F0F);
    rd_chk(1, "R2 event enable readback");
    wr(7, 32'h0000_003C);
    rd_chk(7, "R2 bank1 event enable");

    // R4 rising only, then falling not selected, then both
    wr(2, 32'h0000_0008);
    toggle(3);
    rd_chk(5, "R4 rising latched");
    irq_chk("R11 R12 line3");
    wr(5, 32'h0000_0008);
    toggle(3);
    rd_chk(5, "R4 unselected falling");
    wr(3, 32'h0000_0008);
    toggle(3);
    rd_chk(5, "R4 both selects rising");
    wr(5, 32'h0000_0008);
    toggle(3);
    rd_chk(5, "R4 both selects falling");
    irq_chk("R11 R12 after falling");

    // R5 enable off blocks latching
    wr(0, 32'hFFFF_FF7F);
    wr(2, 32'h0000_0088);
    toggle(7);
    rd_chk(5, "R5 disabled line");
    wr(0, 32'hFFFF_FFFF);

    // R8 software trigger, R6 write-one-to-clear
    wr(4, 32'h0000_F0F0);
    rd_chk(4, "R8 trigger readback");
    rd_chk(5, "R8 trigger sets pending");
    irq_chk("R11 R12 software");
    wr(5, 32'h0);
    rd_chk(5, "R6 zero write");
    wr(5, 32'h0000_00F0);
    rd_chk(5, "R6 partial clear");
    rd_chk(4, "R8 trigger drops with pending");
    wr(0, 32'hFFFF_FFFE);
    wr(4, 32'h0000_0001);
    rd_chk(4, "R8 disabled trigger");
    rd_chk(5, "R8 disabled no pending");
    wr(0, 32'hFFFF_FFFF);

    // R10 enable drop removes request
    wr(0, 32'hFFFF_0FFF);
    irq_chk("R10 enable dropped");
    check("R10 wide group6 low", 32'(irq_a[6]), 32'h0);
    wr(0, 32'hFFFF_FFFF);
    irq_chk("R10 enable restored");
    check("R11 wide group6 high", 32'(irq_a[6]), 32'h1);
    check("R12 compact group2 high", 32'(irq_c[2]), 32'h1);

    // second bank line 35
    wr(8, 32'h0000_0008);
    toggle(35);
    rd_chk(11, "R2 bank1 pending");
    irq_chk("R12 upper line silent");

    // R9 event without interrupt enable
    wr(0, 32'h0);
    wr(3, 32'h0000_0008);
    toggle(3);
    rd_chk(5, "R9 no pending when disabled");
    wr(0, 32'hFFFF_FFFF);

    // R7 set beats clear in the same cycle (line 2 still low)
    wr(2, 32'h0000_0004);
    wr(5, 32'hFFFF_FFFF);
    @(negedge clk);
    lines[2] = ~lines[2];
    @(negedge clk);
    @(negedge clk);
    addr = 4'd5;
    wdata = 32'h0000_0004;
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    model_wr(5, 32'h0000_0004);
    for (int i = 0; i < 2; i++) m[i][5][2] = 1'b1;
    rd_chk(5, "R7 set wins");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: wr(int'($urandom % 14), $urandom);
        1: toggle(int'($urandom % NA));
        2: rd_chk(int'($urandom % 14), "R2 R3 random read");
        default: wr(int'(($urandom % 2) * 6 + 5), $urandom & $urandom);
      endcase
      irq_chk("R11 R12 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule